// File: doc/BRIEF.md
# Peripheral Port Select and Interrupt Instruction Port

This block sits between a small processor core and its surroundings. It decodes I/O cycles into one select strobe per peripheral. It also chooses which byte the processor sees on its input data path: memory data, peripheral input data, or an instruction byte supplied by an interrupting device.

During an I/O cycle the port number is taken from a five-bit field of the latched address. The low eight port numbers are input peripherals and the other twenty-four are output peripherals. Output peripherals take their data from the processor's shared write bus, which does not pass through this block.

A device requests service by driving an opcode onto the interrupt code port and raising the request line. The request is synchronised to the clock and held pending. On the next instruction fetch, the block substitutes the device's opcode for memory data. The pending state clears when that fetch ends.

Top module: `io_port_steer`

## Requirements
- R1: During an I/O cycle in its data-transfer state, with address bits 13 down to 9 holding a port number n below 8, exactly in_sel bit n is high.
- R2: Under the same conditions, with a port number n from 8 to 31, exactly out_sel bit n-8 is high.
- R3: No more than one strobe is high at any time, and all strobes are low whenever the I/O flag or the transfer flag is low.
- R4: During the data-transfer state of an I/O cycle to an input port (0 to 7), with no acknowledge fetch running, cpu_data equals per_in.
- R5: In every other case without an acknowledge fetch, cpu_data equals mem_in.
- R6: A low-to-high change of irq_req is seen by the clock edge that samples it. irq_pend goes high at the second clock edge after that one. irq_pend then stays high until the acknowledge fetch ends.
- R7: An acknowledge fetch starts at the clock edge where irq_pend is high and a fetch cycle is in its first state. While irq_ack is high, cpu_data equals irq_code, taking priority over I/O input and memory data.
- R8: irq_ack falls, and irq_pend clears, at the clock edge of the last state of the acknowledge fetch. A fetch that starts while irq_pend is low does not raise irq_ack.
- R9: Holding irq_req high raises only one request. A new request needs the line to fall and rise again.
- R10: While rst_n is low, irq_pend and irq_ack are low and the synchroniser is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 14 | Latched processor address |
| cyc_fetch | input | 1 | Current cycle is an instruction fetch |
| cyc_io | input | 1 | Current cycle is an I/O cycle |
| cyc_start | input | 1 | First state of a bus cycle |
| cyc_xfer | input | 1 | Data-transfer state of a bus cycle |
| cyc_end | input | 1 | Last state of a bus cycle |
| mem_in | input | 8 | Data read from memory |
| per_in | input | 8 | Data from input peripherals |
| irq_req | input | 1 | Asynchronous interrupt request |
| irq_code | input | 8 | Instruction byte from the interrupting device |
| in_sel | output | 8 | Input port strobes, one per port 0 to 7 |
| out_sel | output | 24 | Output port strobes, bit k for port k+8 |
| cpu_data | output | 8 | Byte presented to the processor |
| irq_pend | output | 1 | Interrupt request latched, not yet serviced |
| irq_ack | output | 1 | Acknowledge fetch in progress |

## Verification
The assertions assume that each bus cycle has a single start state and a single end state, and that the two never fall in the same clock. The ack-release property depends on this. They also assume that irq_code is stable for as long as irq_ack is high. The stimulus meets these assumptions by building every bus cycle from four states: start, wait, transfer, end. The interrupt opcode is changed only while no acknowledge is running. The interrupt line itself is toggled freely between cycles, including during cycles, so the synchroniser and the edge detection are exercised without restriction.

// File: rtl/io_steer_pkg.sv
package io_steer_pkg;

    // Registered interrupt state: three synchroniser stages, the pending
    // latch and the acknowledge-fetch flag.
    typedef struct packed {
        logic sync1;
        logic sync2;
        logic sync3;
        logic pend;
        logic ack;
    } irq_state_t;

    // Source selected for the processor input byte.
    typedef enum logic [1:0] {
        SRC_MEM  = 2'd0,
        SRC_PORT = 2'd1,
        SRC_IRQ  = 2'd2
    } data_src_t;

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode #(
    parameter int ADDR_W   = 14,
    parameter int PORT_LSB = 9,
    parameter int PORT_W   = 5,
    parameter int N_IN     = 8,
    parameter int N_OUT    = (1 << PORT_W) - N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cyc_io,
    input  logic              cyc_xfer,
    output logic [N_IN-1:0]   in_sel,
    output logic [N_OUT-1:0]  out_sel,
    output logic              port_rd
);

    logic [PORT_W-1:0] port_num;
    logic              io_live;

    always_comb begin
        port_num = addr[PORT_LSB +: PORT_W];
        io_live  = cyc_io && cyc_xfer;
        port_rd  = io_live && (port_num < PORT_W'(N_IN));
    end

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in_strobe
        assign in_sel[gi] = io_live && (port_num == PORT_W'(gi));
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_out_strobe
        assign out_sel[go] = io_live && (port_num == PORT_W'(N_IN + go));
    end

    // R3: strobes are mutually exclusive
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_sel, out_sel}));

    // R3: no strobe outside the transfer state of an I/O cycle
    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_io && cyc_xfer) |-> ($countones({in_sel, out_sel}) == 0));

    // R1/R2: a live I/O transfer always selects some port
    a_r1_r2_one_live: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_io && cyc_xfer) |-> ($countones({in_sel, out_sel}) == 1));

endmodule

// File: rtl/io_irq_latch.sv
module io_irq_latch
    import io_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic cyc_fetch,
    input  logic cyc_start,
    input  logic cyc_end,
    output logic irq_pend,
    output logic irq_ack
);

    irq_state_t st_d, st_q;
    logic       new_req;
    logic       ack_done;
    logic       ack_begin;

    always_comb begin
        new_req   = st_q.sync2 && !st_q.sync3;
        ack_done  = st_q.ack && cyc_end;
        ack_begin = !st_q.ack && st_q.pend && cyc_fetch && cyc_start;

        st_d       = st_q;
        st_d.sync1 = irq_req;
        st_d.sync2 = st_q.sync1;
        st_d.sync3 = st_q.sync2;
        st_d.pend  = new_req || (st_q.pend && !ack_done);
        if (ack_done) begin
            st_d.ack = 1'b0;
        end else if (ack_begin) begin
            st_d.ack = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pend = st_q.pend;
    assign irq_ack  = st_q.ack;

    // R7: an acknowledge fetch only begins from a pending request at a fetch start
    a_r7_ack_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack) |-> $past(irq_pend && cyc_fetch && cyc_start));

    // R8: the acknowledge ends with the last state of its fetch
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && cyc_end) |=> !irq_ack);

    // R8: the acknowledge holds until that last state
    a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !cyc_end) |=> irq_ack);

    // R6: a pending request is kept until serviced
    a_r6_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !(irq_ack && cyc_end)) |=> irq_pend);

endmodule

// File: rtl/io_data_steer.sv
module io_data_steer
    import io_steer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              irq_ack,
    input  logic              port_rd,
    input  logic [DATA_W-1:0] irq_code,
    input  logic [DATA_W-1:0] per_in,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] cpu_data
);

    data_src_t src;

    always_comb begin
        if (irq_ack) begin
            src = SRC_IRQ;
        end else if (port_rd) begin
            src = SRC_PORT;
        end else begin
            src = SRC_MEM;
        end

        unique case (src)
            SRC_IRQ:  cpu_data = irq_code;
            SRC_PORT: cpu_data = per_in;
            default:  cpu_data = mem_in;
        endcase
    end

endmodule

// File: rtl/io_port_steer.sv
module io_port_steer
    import io_steer_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 8,
    parameter int PORT_LSB = 9,
    parameter int PORT_W   = 5,
    parameter int N_IN     = 8,
    parameter int N_OUT    = (1 << PORT_W) - N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cyc_fetch,
    input  logic              cyc_io,
    input  logic              cyc_start,
    input  logic              cyc_xfer,
    input  logic              cyc_end,
    input  logic [DATA_W-1:0] mem_in,
    input  logic [DATA_W-1:0] per_in,
    input  logic              irq_req,
    input  logic [DATA_W-1:0] irq_code,
    output logic [N_IN-1:0]   in_sel,
    output logic [N_OUT-1:0]  out_sel,
    output logic [DATA_W-1:0] cpu_data,
    output logic              irq_pend,
    output logic              irq_ack
);

    logic port_rd;

    io_port_decode #(
        .ADDR_W  (ADDR_W),
        .PORT_LSB(PORT_LSB),
        .PORT_W  (PORT_W),
        .N_IN    (N_IN),
        .N_OUT   (N_OUT)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .cyc_io  (cyc_io),
        .cyc_xfer(cyc_xfer),
        .in_sel  (in_sel),
        .out_sel (out_sel),
        .port_rd (port_rd)
    );

    io_irq_latch u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .cyc_fetch(cyc_fetch),
        .cyc_start(cyc_start),
        .cyc_end  (cyc_end),
        .irq_pend (irq_pend),
        .irq_ack  (irq_ack)
    );

    io_data_steer #(
        .DATA_W(DATA_W)
    ) u_steer (
        .irq_ack (irq_ack),
        .port_rd (port_rd),
        .irq_code(irq_code),
        .per_in  (per_in),
        .mem_in  (mem_in),
        .cpu_data(cpu_data)
    );

    // R7: the device opcode wins over every other source during the ack fetch
    a_r7_code_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (cpu_data == irq_code));

    // R4: an input-port transfer outside an ack fetch returns peripheral data
    a_r4_port_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ack && (|in_sel)) |-> (cpu_data == per_in));

    // R5: with no strobe and no ack, memory data passes through
    a_r5_mem_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_ack && !(|in_sel)) |-> (cpu_data == mem_in));

endmodule

// File: tb/io_port_steer_tb.sv
module io_port_steer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] addr;
    logic        cyc_fetch, cyc_io, cyc_start, cyc_xfer, cyc_end;
    logic [7:0]  mem_in, per_in, irq_code;
    logic        irq_req;
    logic [7:0]  in_sel;
    logic [23:0] out_sel;
    logic [7:0]  cpu_data;
    logic        irq_pend, irq_ack;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    bit irq_hist[$];
    bit m_pend, m_ack;

    always #4 clk = ~clk;

    io_port_steer u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cyc_fetch(cyc_fetch), .cyc_io(cyc_io), .cyc_start(cyc_start),
        .cyc_xfer(cyc_xfer), .cyc_end(cyc_end),
        .mem_in(mem_in), .per_in(per_in), .irq_req(irq_req), .irq_code(irq_code),
        .in_sel(in_sel), .out_sel(out_sel), .cpu_data(cpu_data),
        .irq_pend(irq_pend), .irq_ack(irq_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        irq_hist = '{0, 0, 0};
        m_pend = 0;
        m_ack  = 0;
    endtask

    task automatic compare();
        int   port;
        bit   live;
        logic [7:0]  e_in;
        logic [23:0] e_out;
        logic [7:0]  e_data;
        string dtag;
        port  = int'(addr) >> 9;
        live  = cyc_io && cyc_xfer;
        e_in  = '0;
        e_out = '0;
        if (live && port < 8)  e_in  = 8'(1 << port);
        if (live && port >= 8) e_out = 24'(1 << (port - 8));
        if (m_ack) begin
            e_data = irq_code; dtag = "R7 data";
        end else if (live && port < 8) begin
            e_data = per_in;   dtag = "R4 data";
        end else begin
            e_data = mem_in;   dtag = "R5 data";
        end
        chk(in_sel === e_in,    "R1/R3 in_sel",  int'(in_sel),  int'(e_in));
        chk(out_sel === e_out,  "R2/R3 out_sel", int'(out_sel), int'(e_out));
        chk(cpu_data === e_data, dtag,           int'(cpu_data), int'(e_data));
        chk(irq_pend === m_pend, "R6/R9 irq_pend", int'(irq_pend), int'(m_pend));
        chk(irq_ack === m_ack,   "R8 irq_ack",   int'(irq_ack), int'(m_ack));
    endtask

    // inputs are set after a falling edge; compare, then advance one clock
    task automatic tick();
        bit seen, prev, done_ack, n_ack;
        #1 compare();
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            seen     = irq_hist[1];
            prev     = irq_hist[2];
            done_ack = m_ack && cyc_end;
            n_ack    = m_ack ? !cyc_end : (m_pend && cyc_fetch && cyc_start);
            m_pend   = (seen && !prev) || (m_pend && !done_ack);
            m_ack    = n_ack;
            irq_hist.push_front(irq_req);
            void'(irq_hist.pop_back());
        end
        @(negedge clk);
    endtask

    // kind: 0 memory read, 1 fetch, 2 I/O
    task automatic bus_cycle(input int kind, input logic [13:0] a, input bit io_too = 0);
        addr = a;
        for (int s = 0; s < 4; s++) begin
            cyc_fetch = (kind == 1);
            cyc_io    = (kind == 2) || io_too;
            cyc_start = (s == 0);
            cyc_xfer  = (s == 2);
            cyc_end   = (s == 3);
            mem_in    = 8'($urandom);
            per_in    = 8'($urandom);
            tick();
        end
        {cyc_fetch, cyc_io, cyc_start, cyc_xfer, cyc_end} = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst_n = 0;
        addr = '0; {cyc_fetch, cyc_io, cyc_start, cyc_xfer, cyc_end} = '0;
        mem_in = 8'h11; per_in = 8'h22; irq_code = 8'hC7; irq_req = 0;
        @(negedge clk);
        irq_req = 1;  // R10: request during reset is cleared with the synchroniser
        idle(4);
        chk(irq_pend === 0 && irq_ack === 0, "R10 reset state", int'({irq_pend, irq_ack}), 0);
        irq_req = 0;
        idle(1);
        rst_n = 1;
        idle(4);
        chk(irq_pend === 0, "R10 no stale request", int'(irq_pend), 0);

        // R1 R2 R4: every port number
        for (int p = 0; p < 32; p++) bus_cycle(2, 14'((p << 9) | ($urandom & 9'h1FF)));

        // R3 R5: memory and fetch cycles never strobe a port
        for (int i = 0; i < 20; i++) bus_cycle(i % 2, 14'($urandom));

        // R6: pending rises on the second edge after the sampling edge
        irq_code = 8'h3D;
        irq_req = 1;
        tick();  // sampling edge
        tick();
        chk(irq_pend === 0, "R6 not yet pending", int'(irq_pend), 0);
        tick();
        chk(irq_pend === 1, "R6 pending", int'(irq_pend), 1);
        idle(3);
        // R7: acknowledge fetch returns the device opcode
        addr = 14'h0123; cyc_fetch = 1; cyc_start = 1; mem_in = 8'hA5;
        tick();
        cyc_start = 0;
        chk(irq_ack === 1 && cyc_data_ok(8'h3D), "R7 opcode injected", int'(cpu_data), 8'h3D);
        tick(); cyc_xfer = 1; tick(); cyc_xfer = 0; cyc_end = 1; tick();
        {cyc_fetch, cyc_end} = '0;
        chk(irq_ack === 0 && irq_pend === 0, "R8 ack cleared", int'({irq_pend, irq_ack}), 0);

        // R9: line still held high, next fetch is a plain memory fetch
        idle(5);
        bus_cycle(1, 14'h0200);
        chk(irq_pend === 0 && irq_ack === 0, "R9 held line no repeat", int'({irq_pend, irq_ack}), 0);

        // R8: fetch with nothing pending gives memory data
        mem_in = 8'h5A; cyc_fetch = 1; cyc_start = 1;
        tick();
        chk(irq_ack === 0 && cpu_data === 8'h5A, "R8 no ack without pend", int'(cpu_data), 8'h5A);
        {cyc_fetch, cyc_start} = '0;
        idle(2);

        // R9: fall then rise makes a new request; R7 priority over an input port
        irq_req = 0; idle(4);
        irq_code = 8'hE1; irq_req = 1; idle(5);
        chk(irq_pend === 1, "R9 new edge pends", int'(irq_pend), 1);
        bus_cycle(1, 14'((3 << 9)), 1);
        chk(irq_pend === 0, "R7 priority cycle serviced", int'(irq_pend), 0);

        // mixed random traffic with free interrupt toggling
        for (int i = 0; i < 400; i++) begin
            if (!m_ack && ($urandom % 4 == 0)) irq_code = 8'($urandom);
            if ($urandom % 3 == 0) irq_req = ~irq_req;
            if ($urandom % 5 == 0) idle(1 + $urandom % 3);
            else bus_cycle(int'($urandom % 3), 14'($urandom));
        end
        irq_req = 0;
        idle(6);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic bit cyc_data_ok(input logic [7:0] v);
        return cpu_data === v;
    endfunction

endmodule